// File: doc/BRIEF.md
# Lockable Bridge Control and Interrupt Register File

This block is a small register file that sits beside a bus bridge datapath. A simple register port gives software reads and writes to four words: a system control word, a sticky local-bus event status byte, an event mask byte and a bus error status word. The block drives two outputs. One is an active-low reset to the secondary bus. The other is a single interrupt line, which is raised whenever an unmasked event is pending.

A two-state lock machine guards every write. Its states are LOCKED and OPEN. The transition UNLOCK (LOCKED to OPEN) is taken on a write of the key 0xA05F to the system word. The transition RELOCK (OPEN to LOCKED) is taken on a non-key system write whose lock bit is 1. A key write while OPEN stays in OPEN, and every other cycle holds the current state. While LOCKED, the machine refuses every write except the key. Event pulses from the datapath always set their status bits, whatever the lock state. Reset puts the block in LOCKED, with the secondary bus held in reset and all status and mask bits clear.

Read data is combinational from the address. A write takes effect at the clock edge on which `reg_wr` is sampled high.

Top module: `brg_ctl_regs`

## Requirements
- R1: After reset, the system word reads 0x4000 (locked, bus reset bit 0), `bus_rst_n` is 0, the event status, mask and error words all read 0, and `irq` is 0.
- R2: `bus_rst_n` follows bit 15 of the system word. When that bit is 0, the secondary bus is held in reset.
- R3: A write of 0xA05F to the system word (address 0) clears the lock (bit 14) from either lock state and leaves bit 15 unchanged.
- R4: While locked, writes to addresses 1, 2 and 3 and non-key writes to address 0 have no effect on any register or output.
- R5: While unlocked, a non-key write to the system word loads bits 15 and 14 from the write data. Writing bit 14 as 1 relocks the block.
- R6: The event status byte at address 1 has this layout: bit 7 mailbox, bit 6 read abort, bit 5 write abort, bit 4 bus pin interrupt, bit 3 parity error, bit 2 inbound queue post, bit 1 DMA channel 1, bit 0 DMA channel 0. A one-cycle pulse on `lb_evt[i]` sets bit i, and the bit stays set until it is cleared.
- R7: An accepted write to the status byte clears each bit written as 0, so writing 0 clears every pending event. An event pulse in the same cycle as a clearing write leaves its bit set.
- R8: The mask byte at address 2 uses the same layout and takes accepted writes directly. `irq` is 1 exactly when some bit is set in both the status byte and the mask byte.
- R9: The error word at address 3 holds parity error in bit 15, system error in bit 14, master abort in bit 13 and target abort in bit 12. These bits are set by `pci_evt[3:0]` in that order, bit 3 to bit 0. An accepted write clears each bit written as 1, and an event pulse in the same cycle keeps its bit set.
- R10: Bits that are not defined read as 0. This covers bits 13:0 of the system word, bits 15:8 of the status and mask words, and bits 11:0 of the error word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 2 | Word address: 0 system, 1 event status, 2 mask, 3 bus error status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed word (combinational) |
| lb_evt | input | 8 | Local-bus event pulses, one per status bit |
| pci_evt | input | 4 | Bus error pulses: parity, system error, master abort, target abort |
| bus_rst_n | output | 1 | Secondary-bus reset, active low |
| irq | output | 1 | Interrupt: some status bit is set and unmasked |

## Verification
The assertions check several properties on every cycle:
- a key write always leaves the block unlocked;
- a locked cycle never moves the mask, the bus reset output or the lock state, apart from the key write;
- an event pulse always leaves its status bit set;
- no status bit rises without its event;
- an all-zero mask keeps the interrupt low.

Only the bench scenarios can show certain behaviours. These are the exact read values of each word, the clear-on-zero and clear-on-one write rules, which bits a partial clear keeps, the order of UNLOCK and RELOCK across a sequence of writes, and the interrupt rising and falling as the mask changes.

// File: rtl/brg_ctl_pkg.sv
package brg_ctl_pkg;

    localparam int DATA_W  = 16;
    localparam int EVT_W   = 8;
    localparam int PERR_W  = 4;
    localparam int ADDR_W  = 2;
    localparam int PERR_LSB = DATA_W - PERR_W;

    localparam int SYS_RST_BIT  = 15;
    localparam int SYS_LOCK_BIT = 14;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'hA05F;

    localparam logic [ADDR_W-1:0] ADR_SYS  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_EVT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_MASK = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_PERR = 2'd3;

    localparam int EV_DMA0   = 0;
    localparam int EV_DMA1   = 1;
    localparam int EV_QPOST  = 2;
    localparam int EV_PARITY = 3;
    localparam int EV_PIN    = 4;
    localparam int EV_WRABT  = 5;
    localparam int EV_RDABT  = 6;
    localparam int EV_MAIL   = 7;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_st_e;

endpackage

// File: rtl/brg_lock_fsm.sv
module brg_lock_fsm
    import brg_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sys_wr,
    input  logic key_hit,
    input  logic relock_req,
    output logic locked,
    output logic sys_load
);

    lock_st_e state_q;
    lock_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (sys_wr && key_hit) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (sys_wr && !key_hit && relock_req) begin
                    state_d = ST_LOCKED;
                end
            end
        endcase
    end

    always_comb begin
        locked   = 1'b1;
        sys_load = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                locked   = 1'b1;
                sys_load = 1'b0;
            end
            ST_OPEN: begin
                locked   = 1'b0;
                sys_load = sys_wr && !key_hit;
            end
        endcase
    end

endmodule

// File: rtl/brg_wr_reg.sv
module brg_wr_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/brg_sticky_bank.sv
module brg_sticky_bank #(
    parameter int W          = 8,
    parameter bit CLR_ON_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] q
);

    logic [W-1:0] clr;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (CLR_ON_ONE) begin : g_w1c
            assign clr[i] = wr_en && wdata[i];
        end else begin : g_w0c
            assign clr[i] = wr_en && !wdata[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (evt[i]) begin
                q[i] <= 1'b1;
            end else if (clr[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/brg_ctl_regs.sv
module brg_ctl_regs
    import brg_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0]  lb_evt,
    input  logic [PERR_W-1:0] pci_evt,
    output logic              bus_rst_n,
    output logic              irq
);

    logic              sys_wr;
    logic              key_hit;
    logic              locked_w;
    logic              sys_load;
    logic              wr_ok;
    logic              rst_bit_q;
    logic [EVT_W-1:0]  mask_q;
    logic [EVT_W-1:0]  evt_q;
    logic [PERR_W-1:0] perr_q;

    assign sys_wr  = reg_wr && (reg_addr == ADR_SYS);
    assign key_hit = (reg_wdata == UNLOCK_KEY);
    assign wr_ok   = reg_wr && !locked_w;

    brg_lock_fsm u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_wr     (sys_wr),
        .key_hit    (key_hit),
        .relock_req (reg_wdata[SYS_LOCK_BIT]),
        .locked     (locked_w),
        .sys_load   (sys_load)
    );

    brg_wr_reg #(.W(1)) u_sysrst (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sys_load),
        .d     (reg_wdata[SYS_RST_BIT]),
        .q     (rst_bit_q)
    );

    brg_wr_reg #(.W(EVT_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_ok && (reg_addr == ADR_MASK)),
        .d     (reg_wdata[EVT_W-1:0]),
        .q     (mask_q)
    );

    brg_sticky_bank #(.W(EVT_W), .CLR_ON_ONE(1'b0)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ok && (reg_addr == ADR_EVT)),
        .wdata (reg_wdata[EVT_W-1:0]),
        .evt   (lb_evt),
        .q     (evt_q)
    );

    brg_sticky_bank #(.W(PERR_W), .CLR_ON_ONE(1'b1)) u_perr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ok && (reg_addr == ADR_PERR)),
        .wdata (reg_wdata[DATA_W-1:PERR_LSB]),
        .evt   (pci_evt),
        .q     (perr_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_SYS: begin
                reg_rdata[SYS_RST_BIT]  = rst_bit_q;
                reg_rdata[SYS_LOCK_BIT] = locked_w;
            end
            ADR_EVT:  reg_rdata[EVT_W-1:0] = evt_q;
            ADR_MASK: reg_rdata[EVT_W-1:0] = mask_q;
            ADR_PERR: reg_rdata[DATA_W-1:PERR_LSB] = perr_q;
        endcase
    end

    assign bus_rst_n = rst_bit_q;
    assign irq       = |(evt_q & mask_q);

endmodule

// File: rtl/brg_ctl_regs_chk.sv
module brg_ctl_regs_chk
    import brg_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [EVT_W-1:0]  lb_evt,
    input logic [PERR_W-1:0] pci_evt,
    input logic              locked,
    input logic [EVT_W-1:0]  mask_q,
    input logic [EVT_W-1:0]  evt_q,
    input logic [PERR_W-1:0] perr_q,
    input logic              irq,
    input logic              bus_rst_n
);

    logic key_wr;
    assign key_wr = reg_wr && (reg_addr == ADR_SYS) && (reg_wdata == UNLOCK_KEY);

    AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> !locked) else $error("key write left block locked"); // R3

    AST_LOCKED_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mask_q)) else $error("mask moved while locked"); // R4

    AST_LOCKED_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(bus_rst_n)) else $error("bus reset moved while locked"); // R4

    AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !key_wr) |=> locked) else $error("lock dropped without key"); // R3

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_evt != '0) |=> ((evt_q & $past(lb_evt)) == $past(lb_evt)))
        else $error("event pulse lost"); // R7

    AST_NO_SPURIOUS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(lb_evt)) == '0))
        else $error("status rose without event"); // R6

    AST_PERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_evt != '0) |=> ((perr_q & $past(pci_evt)) == $past(pci_evt)))
        else $error("error pulse lost"); // R9

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq) else $error("irq with empty mask"); // R8

endmodule

bind brg_ctl_regs brg_ctl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .lb_evt    (lb_evt),
    .pci_evt   (pci_evt),
    .locked    (locked_w),
    .mask_q    (mask_q),
    .evt_q     (evt_q),
    .perr_q    (perr_q),
    .irq       (irq),
    .bus_rst_n (bus_rst_n)
);

// File: tb/brg_ctl_regs_tb.sv
`timescale 1ns/1ps
module brg_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [7:0]  lb_evt = 8'd0;
    logic [3:0]  pci_evt = 4'd0;
    logic        bus_rst_n;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [17:0] exp_q[$];
    string       tag_q[$];
    event        smp;

    always #4 clk = ~clk;

    brg_ctl_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lb_evt    (lb_evt),
        .pci_evt   (pci_evt),
        .bus_rst_n (bus_rst_n),
        .irq       (irq)
    );

    // Monitor: pops expected items and compares them with the ports
    always begin
        @(smp);
        while (exp_q.size() > 0) begin
            logic [17:0] it;
            logic [15:0] act;
            string t;
            it = exp_q.pop_front();
            t  = tag_q.pop_front();
            case (it[17:16])
                2'd0:    act = reg_rdata;
                2'd1:    act = {15'd0, irq};
                default: act = {15'd0, bus_rst_n};
            endcase
            n_chk++;
            if (act !== it[15:0]) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", t, act, it[15:0]);
            end
        end
    end

    task automatic exp_rd(input logic [1:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        reg_addr = a;
        exp_q.push_back({2'd0, e});
        tag_q.push_back(t);
        #2 ->smp;
    endtask

    task automatic exp_pin(input logic [1:0] k, input logic v, input string t);
        @(negedge clk);
        exp_q.push_back({k, 15'd0, v});
        tag_q.push_back(t);
        #2 ->smp;
    endtask

    task automatic wr_evt(input logic [1:0] a, input logic [15:0] d, input logic do_wr,
                          input logic [7:0] le, input logic [3:0] pe);
        @(negedge clk);
        reg_wr    = do_wr;
        reg_addr  = a;
        reg_wdata = d;
        lb_evt    = le;
        pci_evt   = pe;
        @(negedge clk);
        reg_wr  = 1'b0;
        lb_evt  = 8'd0;
        pci_evt = 4'd0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_evt(a, d, 1'b1, 8'd0, 4'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_rd(2'd0, 16'h4000, "R1 sys after reset");
        exp_pin(2'd2, 1'b0, "R1 bus_rst_n after reset");
        exp_rd(2'd1, 16'h0000, "R1 status after reset");
        exp_rd(2'd2, 16'h0000, "R1 mask after reset");
        exp_rd(2'd3, 16'h0000, "R1 error word after reset");
        exp_pin(2'd1, 1'b0, "R1 irq after reset");

        // R4 locked writes are refused
        wr(2'd2, 16'h00FF);
        exp_rd(2'd2, 16'h0000, "R4 mask write while locked");
        wr(2'd0, 16'h8000);
        exp_rd(2'd0, 16'h4000, "R4 sys write while locked");
        exp_pin(2'd2, 1'b0, "R4 bus_rst_n while locked");

        // R3 key unlocks
        wr(2'd0, 16'hA05F);
        exp_rd(2'd0, 16'h0000, "R3 key clears lock");

        // R2 R5 system word load
        wr(2'd0, 16'h8000);
        exp_rd(2'd0, 16'h8000, "R5 sys load");
        exp_pin(2'd2, 1'b1, "R2 bus reset released");
        wr(2'd0, 16'hFFFF);
        exp_rd(2'd0, 16'hC000, "R5 R10 relock with other bits zero");
        wr(2'd0, 16'hA05F);
        exp_rd(2'd0, 16'h8000, "R3 key keeps reset bit");
        wr(2'd0, 16'h0000);
        exp_pin(2'd2, 1'b0, "R2 bus reset asserted");

        // R6 R8 events and mask
        wr_evt(2'd0, 16'h0000, 1'b0, 8'h81, 4'd0);
        exp_rd(2'd1, 16'h0081, "R6 mailbox and dma0 set");
        exp_pin(2'd1, 1'b0, "R8 irq masked");
        wr(2'd2, 16'h0001);
        exp_rd(2'd2, 16'h0001, "R8 mask write");
        exp_pin(2'd1, 1'b1, "R8 irq unmasked");
        wr(2'd2, 16'h0040);
        exp_pin(2'd1, 1'b0, "R8 irq with other mask bit");

        // R7 clear rules
        wr(2'd1, 16'h0080);
        exp_rd(2'd1, 16'h0080, "R7 partial clear");
        wr_evt(2'd1, 16'h0000, 1'b1, 8'h20, 4'd0);
        exp_rd(2'd1, 16'h0020, "R7 set wins over clear");
        wr(2'd1, 16'h0000);
        exp_rd(2'd1, 16'h0000, "R7 zero clears all");

        // R9 error word
        wr_evt(2'd0, 16'h0000, 1'b0, 8'd0, 4'b1010);
        exp_rd(2'd3, 16'hA000, "R9 parity and master abort");
        wr(2'd3, 16'h8000);
        exp_rd(2'd3, 16'h2000, "R9 write one clears");
        wr_evt(2'd3, 16'h3000, 1'b1, 8'd0, 4'b0001);
        exp_rd(2'd3, 16'h1000, "R9 set wins over clear");

        // R4 relocked: other registers hold
        wr_evt(2'd0, 16'h0000, 1'b0, 8'h10, 4'd0);
        wr(2'd0, 16'h4000);
        exp_rd(2'd0, 16'h4000, "R5 relock");
        wr(2'd1, 16'h0000);
        exp_rd(2'd1, 16'h0010, "R4 status clear while locked");
        wr(2'd3, 16'hF000);
        exp_rd(2'd3, 16'h1000, "R4 error clear while locked");
        wr(2'd2, 16'h0010);
        exp_rd(2'd2, 16'h0040, "R4 mask hold while locked");
        exp_pin(2'd1, 1'b0, "R4 irq unchanged while locked");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule